// File: doc/BRIEF.md
# Shared-Interval Input Deglitch Filter

This block cleans up a bank of asynchronous digital input channels before they reach an edge detector. Every raw input is first brought into the system clock domain by a two-flop synchronizer. Each channel then either passes its synchronized value straight through, or runs through a glitch filter. A filtered channel adopts a new level only after that level has been seen on a programmed number of consecutive 200 ns ticks.

All filtered channels share one 20-bit interval, counted in ticks. A per-channel enable bit chooses which channels are filtered. The enable bits are grouped into one 8-bit register per port of eight channels. Software programs the interval and the enables through a simple synchronous write bus with combinational read-back. The tick is a single-cycle enable supplied from outside at a 200 ns rate.

Top module: `deglitch_bank`

## Requirements
- R1: After reset the interval is zero, every enable bit is zero and every filtered output is zero.
- R2: A write to address 0x08 stores bits 19:0 of the write data as the interval, and a read there returns the interval zero-extended to 32 bits. Port p's enable register sits at address 0x44 + 0x10*p, and bit n of it controls channel 8*p + n. It reads back in bits 7:0. Any other address reads zero.
- R3: Each raw input passes two synchronizer flops and the output flop. A change on an unfiltered channel therefore appears at the output on the third rising clock edge after it is applied.
- R4: A channel whose enable bit is zero drives, at each edge, its synchronized input as sampled before that edge.
- R5: While the interval is zero, enabled channels behave exactly as unfiltered ones.
- R6: With interval N > 0, a filtered output takes a new level only at the tick edge on which the synchronized input has shown that level on N consecutive tick edges. With a tick on every cycle, the output changes on edge N+2 after the raw change.
- R7: If the synchronized input leaves the candidate level before the count completes, the count restarts from zero.
- R8: Only edges with tick high advance a filter count. With tick low, a filtered output does not change.
- R9: Clearing a channel's enable bit makes its output equal its synchronized input on the clock edge after the write edge.
- R10: The single interval applies to every enabled channel across all ports, and each channel keeps its own count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 200 ns time-base enable |
| raw_in | input | NUM_PORTS*8 | Asynchronous raw channel inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back data for reg_addr |
| filt_out | output | NUM_PORTS*8 | Filtered channel outputs |

## Verification
The hardest situation to reach is a filter count that is partly done when something disturbs it. The disturbance may be a one-cycle return to the old level, a stretch with no ticks, or a register write that clears the enable or changes the shared interval. Directed sequences place each of these disturbances at a chosen edge of a running count. A long random phase then uses sparse input toggles, irregular ticks and occasional register writes. It compares every output bit each cycle against a cycle-level reference model, so the counts are hit at many points of completion.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
    localparam int IVL_W    = 20;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int IVL_ADDR = 8;
    localparam int EN_BASE  = 'h44;
    localparam int EN_STEP  = 'h10;

    typedef logic [IVL_W-1:0] ivl_t;

    typedef struct packed {
        logic out;
        logic cand;
        ivl_t cnt;
    } chan_state_t;

    function automatic logic [ADDR_W-1:0] en_addr(input int unsigned p);
        return ADDR_W'(EN_BASE + p * EN_STEP);
    endfunction
endpackage

// File: rtl/deglitch_sync.sv
module deglitch_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/deglitch_regs.sv
module deglitch_regs
    import deglitch_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output ivl_t                        interval,
    output logic [NUM_PORTS*PORT_W-1:0] en_flat
);
    logic [PORT_W-1:0] en_q [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst)
            interval <= '0;
        else if (we && addr == ADDR_W'(IVL_ADDR))
            interval <= wdata[IVL_W-1:0];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)
                en_q[p] <= '0;
            else if (we && addr == en_addr(p))
                en_q[p] <= wdata[PORT_W-1:0];
        end
        assign en_flat[p*PORT_W +: PORT_W] = en_q[p];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(IVL_ADDR))
            rdata[IVL_W-1:0] = interval;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == en_addr(p))
                rdata[PORT_W-1:0] = en_q[p];
        end
    end
endmodule

// File: rtl/deglitch_chan.sv
module deglitch_chan
    import deglitch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sync_in,
    input  logic en,
    input  ivl_t interval,
    output logic filt
);
    chan_state_t st_q, st_d;
    ivl_t        base;
    logic        done;

    always_comb begin
        st_d = st_q;
        base = '0;
        done = 1'b0;
        if (!en || interval == '0) begin
            st_d.out  = sync_in;
            st_d.cand = sync_in;
            st_d.cnt  = '0;
        end else if (sync_in == st_q.out) begin
            st_d.cand = sync_in;
            st_d.cnt  = '0;
        end else begin
            base      = (sync_in == st_q.cand) ? st_q.cnt : '0;
            st_d.cand = sync_in;
            st_d.cnt  = base;
            if (tick) begin
                done = ({1'b0, base} + (IVL_W+1)'(1)) >= {1'b0, interval};
                if (done) begin
                    st_d.out = sync_in;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = base + IVL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{out: 1'b0, cand: 1'b0, cnt: '0};
        else
            st_q <= st_d;
    end

    assign filt = st_q.out;
endmodule

// File: rtl/deglitch_bank.sv
module deglitch_bank
    import deglitch_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int NCH      = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NCH-1:0]    raw_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    filt_out
);
    logic [NCH-1:0] sync_q;
    logic [NCH-1:0] en_flat;
    ivl_t           interval_q;

    deglitch_sync #(.W(NCH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    deglitch_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .interval (interval_q),
        .en_flat  (en_flat)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        deglitch_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .sync_in  (sync_q[c]),
            .en       (en_flat[c]),
            .interval (interval_q),
            .filt     (filt_out[c])
        );
    end
endmodule

// File: rtl/deglitch_bank_chk.sv
module deglitch_bank_chk #(
    parameter int NCH   = 32,
    parameter int IVL_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [NCH-1:0]   raw_in,
    input logic [NCH-1:0]   sync_q,
    input logic [NCH-1:0]   en_flat,
    input logic [IVL_W-1:0] interval_q,
    input logic [NCH-1:0]   filt_out
);
    logic [NCH-1:0] act;
    assign act = en_flat & {NCH{interval_q != '0}};

    // R1: reset clears the programmed state and the outputs
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (interval_q == '0 && en_flat == '0 && filt_out == '0));

    // R3: synchronized value is the raw input two edges back
    assert_two_flop_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_q == $past(raw_in, 2)));

    // R4, R5, R9: inactive channels copy the prior synchronized value
    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((filt_out ^ $past(sync_q)) & ~$past(act)) == '0));

    // R8: filtered outputs hold on edges without a tick
    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |->
            (((filt_out ^ $past(filt_out)) & $past(act)) == '0));

    // R6: a filtered output only moves to the level being sampled
    assert_moves_to_sample_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
            (((filt_out ^ $past(filt_out)) & $past(act) & (filt_out ^ $past(sync_q))) == '0));
endmodule

bind deglitch_bank deglitch_bank_chk #(
    .NCH   (NCH),
    .IVL_W (deglitch_pkg::IVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .raw_in     (raw_in),
    .sync_q     (sync_q),
    .en_flat    (en_flat),
    .interval_q (interval_q),
    .filt_out   (filt_out)
);

// File: tb/deglitch_bank_tb.sv
module deglitch_bank_tb;
    localparam int NP  = 4;
    localparam int NCH = NP * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick = 1'b1;
    logic [NCH-1:0]  raw_in = '0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  filt_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [NCH-1:0] m_s1, m_s2, m_out, m_cand;
    int             m_cnt [NCH];
    logic [NCH-1:0] m_en;
    int             m_ivl;

    always #5 clk = ~clk;

    deglitch_bank #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .raw_in(raw_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .filt_out(filt_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_out = '0; m_cand = '0; m_en = '0; m_ivl = 0;
            for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
            return;
        end
        for (int c = 0; c < NCH; c++) begin
            if (!m_en[c] || m_ivl == 0) begin
                m_out[c] = m_s2[c]; m_cand[c] = m_s2[c]; m_cnt[c] = 0;
            end else if (m_s2[c] == m_out[c]) begin
                m_cand[c] = m_s2[c]; m_cnt[c] = 0;
            end else begin
                int run;
                run = (m_s2[c] == m_cand[c]) ? m_cnt[c] : 0;
                m_cand[c] = m_s2[c];
                if (tick) run++;
                if (run >= m_ivl) begin
                    m_out[c] = m_s2[c]; m_cnt[c] = 0;
                end else m_cnt[c] = run;
            end
        end
        m_s2 = m_s1;
        m_s1 = raw_in;
        if (reg_we) begin
            if (reg_addr == 8'h08) m_ivl = int'(reg_wdata[19:0]);
            for (int p = 0; p < NP; p++)
                if (reg_addr == 8'(8'h44 + 8'h10 * p)) m_en[p*8 +: 8] = reg_wdata[7:0];
        end
    endtask

    // one clock: model follows, outputs sampled 1 ns after the edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        check(filt_out === m_out, "R4,R6,R7,R8 model", filt_out, m_out);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic flush();
        raw_in = '0; tick = 1'b1;
        for (int p = 0; p < NP; p++) wr(8'(8'h44 + 8'h10 * p), 32'h0);
        idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        rst = 1'b1;
        model_step();
        repeat (3) cyc();
        rst = 1'b0;
        #1;
        // R1 reset state
        check(filt_out === '0, "R1 outputs", filt_out, 0);
        rd_check(8'h08, 32'h0, "R1 interval");
        rd_check(8'h44, 32'h0, "R1 enable p0");
        rd_check(8'h74, 32'h0, "R1 enable p3");

        // R2 register map
        wr(8'h08, 32'hFFF1_2345);
        rd_check(8'h08, 32'h0001_2345, "R2 interval 20-bit");
        wr(8'h54, 32'h1234_56A5);
        rd_check(8'h54, 32'h0000_00A5, "R2 port1 enable");
        rd_check(8'h44, 32'h0, "R2 port0 untouched");
        rd_check(8'h45, 32'h0, "R2 unmapped");
        wr(8'h54, 32'h0);
        wr(8'h08, 32'h0);
        idle(4);

        // R3 / R4 unfiltered latency
        raw_in[0] = 1'b1;
        idle(2);
        check(filt_out[0] === 1'b0, "R3 before third edge", filt_out[0], 0);
        cyc();
        check(filt_out[0] === 1'b1, "R3,R4 third edge", filt_out[0], 1);
        flush();

        // R5 interval zero with enable set
        wr(8'h44, 32'hFF);
        raw_in[6] = 1'b1;
        idle(2);
        check(filt_out[6] === 1'b0, "R5 before third edge", filt_out[6], 0);
        cyc();
        check(filt_out[6] === 1'b1, "R5 passes", filt_out[6], 1);
        flush();

        // R6 interval 4, tick each cycle: change on edge 6
        wr(8'h08, 32'd4);
        wr(8'h44, 32'hFF);
        raw_in[1] = 1'b1;
        idle(5);
        check(filt_out[1] === 1'b0, "R6 edge 5", filt_out[1], 0);
        cyc();
        check(filt_out[1] === 1'b1, "R6 edge 6", filt_out[1], 1);

        // R7 short pulse and an interrupted run
        raw_in[2] = 1'b1; idle(3); raw_in[2] = 1'b0;
        idle(10);
        check(filt_out[2] === 1'b0, "R7 short pulse rejected", filt_out[2], 0);
        raw_in[2] = 1'b1; idle(3); raw_in[2] = 1'b0; cyc(); raw_in[2] = 1'b1;
        idle(5);
        check(filt_out[2] === 1'b0, "R7 restart edge 5", filt_out[2], 0);
        cyc();
        check(filt_out[2] === 1'b1, "R7 restart edge 6", filt_out[2], 1);
        flush();

        // R8 no tick, no progress
        wr(8'h08, 32'd2);
        wr(8'h44, 32'hFF);
        tick = 1'b0;
        raw_in[4] = 1'b1;
        idle(20);
        check(filt_out[4] === 1'b0, "R8 held without tick", filt_out[4], 0);
        tick = 1'b1;
        cyc();
        check(filt_out[4] === 1'b0, "R8 one tick", filt_out[4], 0);
        cyc();
        check(filt_out[4] === 1'b1, "R8 two ticks", filt_out[4], 1);
        flush();

        // R9 clearing the enable mid-count
        wr(8'h08, 32'd1000);
        wr(8'h44, 32'hFF);
        raw_in[3] = 1'b1;
        idle(10);
        check(filt_out[3] === 1'b0, "R9 still filtering", filt_out[3], 0);
        wr(8'h44, 32'hF7);
        check(filt_out[3] === 1'b0, "R9 write edge", filt_out[3], 0);
        cyc();
        check(filt_out[3] === 1'b1, "R9 next edge", filt_out[3], 1);
        flush();

        // R10 shared interval across ports, mixed with unfiltered port 1
        wr(8'h08, 32'd3);
        wr(8'h44, 32'hFF);
        wr(8'h64, 32'hFF);
        raw_in[5] = 1'b1; raw_in[17] = 1'b1; raw_in[9] = 1'b1;
        idle(3);
        check(filt_out[9] === 1'b1, "R10 unfiltered port1", filt_out[9], 1);
        cyc();
        check({filt_out[17], filt_out[5]} === 2'b00, "R10 edge 4", {filt_out[17], filt_out[5]}, 0);
        cyc();
        check({filt_out[17], filt_out[5]} === 2'b11, "R10 edge 5", {filt_out[17], filt_out[5]}, 3);
        flush();

        // random phase against the model
        wr(8'h08, 32'd3);
        for (int p = 0; p < NP; p++) wr(8'(8'h44 + 8'h10 * p), 32'h5A);
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 3) != 0;
            for (int c = 0; c < NCH; c++)
                if ($urandom % 16 == 0) raw_in[c] = ~raw_in[c];
            if ($urandom % 50 == 0) begin
                reg_we = 1'b1;
                if ($urandom % 2 == 0) begin
                    reg_addr = 8'h08;
                    reg_wdata = ($urandom % 6 == 0) ? 32'h0 : 32'($urandom % 8 + 1);
                end else begin
                    reg_addr = 8'(8'h44 + 8'h10 * ($urandom % NP));
                    reg_wdata = 32'($urandom);
                end
            end
            cyc();
            reg_we = 1'b0;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule